// File: doc/BRIEF.md
# Extended-Blank Vertical Line Counter

This block is the vertical counter of a display timing generator. It advances once for each line-end strobe and wraps to the first line of a new frame when the programmed line total is reached. The primary count is CW bits wide, 15 by default, so one frame of plain counting is limited to 32768 lines.

Longer frames come from a stop mechanism. When the primary count is about to step onto a programmed stop line, it takes that value and holds. A secondary counter then runs for a programmed number of lines. After that the primary count carries on from the stop line. Setting the stop line to all ones, or the stop length to zero, turns the mechanism off.

For variable refresh, an external trigger can end a frame early once the current line count has reached the programmed minimum. This also works while the secondary counter is running. The limits, the stop line and the stop length are sampled into shadow copies during reset and on every frame wrap. A change written mid-frame therefore applies from the next frame.

Top module: `vline_ext_counter`

## Requirements
- R1: During and after reset, vcount and ext_count are 0, and halted and frame_start are low.
- R2: With the extension off (cfg_stop all ones, or cfg_stop_len equal to 0), vcount steps 0, 1, ..., cfg_vmax on successive line ends and then wraps to 0, so a frame lasts cfg_vmax+1 lines.
- R3: When a line end would move vcount onto the stop line S, vcount becomes S and halted rises with ext_count at 0. Each later line end increments ext_count. The line end that finds ext_count at cfg_stop_len-1 clears halted and ext_count and leaves vcount at S, after which counting resumes. With vmax 6, S 4 and length 5, the per-line vcount is 0,1,2,3,4,4,4,4,4,4,5,6, and the frame is 12 lines long.
- R4: halted is high exactly while the secondary count runs; whenever halted is low, ext_count is 0.
- R5: A trigger pulse seen at a line end, or in any cycle since the previous line end, ends the frame at that line end if the current vcount is at least cfg_vmin. Both counts then go to 0 and halted goes low.
- R6: A trigger accepted while halted (stop line at or above cfg_vmin) ends the frame at once, without finishing the inserted lines.
- R7: A trigger when vcount is below cfg_vmin is ignored. It is also not remembered past the next line end.
- R8: frame_start is a one-cycle pulse, high in the first cycle in which a new frame's vcount of 0 is visible, and only after a wrapping line end.
- R9: Configuration is applied only at reset and at a frame wrap. A change made mid-frame first affects the following frame.
- R10: In cycles without a line end, vcount, ext_count and halted do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_end | input | 1 | One-cycle pulse at the end of each line |
| trig | input | 1 | Variable-refresh frame-end request pulse |
| cfg_vmin | input | CW | Earliest line (total minus one) at which a trigger is honoured |
| cfg_vmax | input | CW | Last line of a frame (total minus one) |
| cfg_stop | input | CW | Line at which the primary count holds |
| cfg_stop_len | input | TW | Number of inserted lines |
| vcount | output | CW | Primary line count |
| ext_count | output | TW | Secondary count while halted |
| halted | output | 1 | High while inserted lines run |
| frame_start | output | 1 | One-cycle pulse at the start of a frame |

## Verification
Every result of a line end, a trigger or a frame wrap is registered, so it is due exactly one clock after the strobing edge.

The bench drives the strobe for one cycle starting at a falling edge. It samples all outputs at the next falling edge, which follows the single rising edge that consumes the strobe. A trigger given on an idle cycle is checked at the line end that follows it.

Stability with no strobe, and the one-cycle width of frame_start, are checked on extra idle cycles between strobes.

// File: rtl/vline_ext_counter.sv
`timescale 1ns/1ps
module vline_ext_counter #(
  parameter int CW = 15,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          trig,
  input  logic [CW-1:0] cfg_vmin,
  input  logic [CW-1:0] cfg_vmax,
  input  logic [CW-1:0] cfg_stop,
  input  logic [TW-1:0] cfg_stop_len,
  output logic [CW-1:0] vcount,
  output logic [TW-1:0] ext_count,
  output logic          halted,
  output logic          frame_start
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] sh_vmin, sh_vmax, sh_stop;
  logic [TW-1:0] sh_len;
  logic          pend;

  wire [CW-1:0] vnext  = vcount + CW'(1);
  wire          ext_en = (sh_len != '0) && (sh_stop != CMAX);
  wire          early  = (pend | trig) && (vcount >= sh_vmin);
  wire          at_end = !halted && (vcount == sh_vmax);
  wire          wrap   = line_end && (early || at_end);
  wire          enter  = !halted && ext_en && (vnext == sh_stop);
  wire          leave  = (ext_count == sh_len - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || wrap) begin
      sh_vmin <= cfg_vmin;
      sh_vmax <= cfg_vmax;
      sh_stop <= cfg_stop;
      sh_len  <= cfg_stop_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcount      <= '0;
      ext_count   <= '0;
      halted      <= 1'b0;
      frame_start <= 1'b0;
      pend        <= 1'b0;
    end else begin
      frame_start <= wrap;
      if (line_end)  pend <= 1'b0;
      else if (trig) pend <= 1'b1;
      if (wrap) begin
        vcount    <= '0;
        ext_count <= '0;
        halted    <= 1'b0;
      end else if (line_end) begin
        if (halted) begin
          if (leave) begin
            halted    <= 1'b0;
            ext_count <= '0;
          end else begin
            ext_count <= ext_count + TW'(1);
          end
        end else if (enter) begin
          vcount    <= sh_stop;
          halted    <= 1'b1;
          ext_count <= '0;
        end else begin
          vcount <= vnext;
        end
      end
    end
  end
endmodule

module vline_ext_counter_chk #(
  parameter int CW = 15,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_end,
  input logic [CW-1:0] vcount,
  input logic [TW-1:0] ext_count,
  input logic          halted,
  input logic          frame_start,
  input logic [CW-1:0] sh_stop
);
  assert_ext_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> ext_count == '0);

  assert_hold_at_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> vcount == sh_stop);

  assert_entry_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> ext_count == '0);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcount) && $stable(ext_count) && $stable(halted));

  assert_fs_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> vcount == '0 && ext_count == '0 && !halted);

  assert_fs_after_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(line_end));
endmodule

bind vline_ext_counter vline_ext_counter_chk #(.CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_end(line_end), .vcount(vcount),
  .ext_count(ext_count), .halted(halted), .frame_start(frame_start),
  .sh_stop(sh_stop)
);

// File: tb/vline_ext_counter_test.sv
`timescale 1ns/1ps
module vline_ext_counter_test;
  localparam int CW = 15;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0, line_end = 1'b0, trig = 1'b0;
  logic [CW-1:0] cfg_vmin = '0, cfg_vmax = '0, cfg_stop = '1;
  logic [TW-1:0] cfg_stop_len = '0;
  logic [CW-1:0] vcount;
  logic [TW-1:0] ext_count;
  logic halted, frame_start;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  vline_ext_counter #(.CW(CW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .trig(trig),
    .cfg_vmin(cfg_vmin), .cfg_vmax(cfg_vmax), .cfg_stop(cfg_stop),
    .cfg_stop_len(cfg_stop_len), .vcount(vcount), .ext_count(ext_count),
    .halted(halted), .frame_start(frame_start)
  );

  localparam int EX_VC[12] = '{1,2,3,4,4,4,4,4,4,5,6,0};
  localparam int EX_XC[12] = '{0,0,0,0,1,2,3,4,0,0,0,0};
  localparam int EX_HL[12] = '{0,0,0,1,1,1,1,1,0,0,0,0};

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic state_chk(string req, int vc, int xc, int hl, int fs);
    chk({req, " vcount"}, int'(vcount), vc);
    chk({req, " ext_count"}, int'(ext_count), xc);
    chk({req, " halted"}, int'(halted), hl);
    chk({req, " frame_start"}, int'(frame_start), fs);
  endtask

  task automatic configure(int vmin, int vmax, int stop, int len);
    cfg_vmin = CW'(vmin);
    cfg_vmax = CW'(vmax);
    cfg_stop = CW'(stop);
    cfg_stop_len = TW'(len);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic line(bit t);
    line_end = 1'b1;
    trig = t;
    @(negedge clk);
    line_end = 1'b0;
    trig = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    configure(3, 5, 32767, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    state_chk("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    state_chk("R1 after reset", 0, 0, 0, 0);
  endtask

  task automatic t_plain();
    configure(5, 5, 32767, 3);
    do_reset();
    for (int i = 1; i <= 5; i++) begin
      line(1'b0);
      chk("R2 stop all ones", int'(vcount), i);
      chk("R2 no halt", int'(halted), 0);
    end
    line(1'b0);
    state_chk("R2 wrap", 0, 0, 0, 1);
    idle(1);
    chk("R8 pulse one cycle", int'(frame_start), 0);
    configure(4, 4, 2, 0);
    do_reset();
    for (int i = 1; i <= 4; i++) begin
      line(1'b0);
      chk("R2 zero length", int'(vcount), i);
      chk("R2 zero length halt", int'(halted), 0);
    end
    line(1'b0);
    state_chk("R2 zero length wrap", 0, 0, 0, 1);
  endtask

  task automatic t_example();
    configure(6, 6, 4, 5);
    do_reset();
    for (int i = 0; i < 12; i++) begin
      line(1'b0);
      state_chk("R3 long frame", EX_VC[i], EX_XC[i], EX_HL[i], (i == 11) ? 1 : 0);
      if (i == 5) begin
        idle(2);
        state_chk("R10 idle while halted", EX_VC[i], EX_XC[i], 1, 0);
      end
    end
  endtask

  task automatic t_vrr_halt();
    configure(3, 10, 3, 4);
    do_reset();
    line(1'b0);
    line(1'b1);
    state_chk("R7 early trigger ignored", 2, 0, 0, 0);
    line(1'b0);
    state_chk("R3 enter halt", 3, 0, 1, 0);
    line(1'b0);
    state_chk("R7 not remembered", 3, 1, 1, 0);
    line(1'b1);
    state_chk("R6 trigger while halted", 0, 0, 0, 1);
  endtask

  task automatic t_vrr_plain();
    configure(2, 10, 32767, 0);
    do_reset();
    repeat (3) line(1'b0);
    chk("R5 setup", int'(vcount), 3);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    idle(2);
    state_chk("R10 trigger without line end", 3, 0, 0, 0);
    line(1'b0);
    state_chk("R5 pending trigger ends frame", 0, 0, 0, 1);
    line(1'b0);
    line(1'b0);
    line(1'b1);
    state_chk("R5 trigger at vmin", 0, 0, 0, 1);
  endtask

  task automatic t_shadow();
    configure(3, 3, 32767, 0);
    do_reset();
    line(1'b0);
    configure(5, 5, 32767, 0);
    line(1'b0);
    line(1'b0);
    chk("R9 old vmax still used", int'(vcount), 3);
    line(1'b0);
    state_chk("R9 wrap on old vmax", 0, 0, 0, 1);
    for (int i = 1; i <= 5; i++) begin
      line(1'b0);
      chk("R9 new vmax", int'(vcount), i);
    end
    line(1'b0);
    state_chk("R9 wrap on new vmax", 0, 0, 0, 1);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_plain();
    t_example();
    t_vrr_halt();
    t_vrr_plain();
    t_shadow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule